// File: doc/BRIEF.md
# Linear Circuit-Switched Stream Switch Node

This block is one node in a chain of switches that carries point-to-point data streams between modules placed along a line. Each node has a group of channels running toward its left neighbour, a group toward its right neighbour, and a group of local ports that face an attached module. In both directions every channel is a bundle. Forward wires carry the request, the destination index, data and valid. Backward wires carry grant, deny and full.

A producer holds a level request and names a destination node index. Each node compares that index with its own index, which is fixed by a parameter. It claims one free outgoing channel in the matching group: right when the destination is larger, left when it is smaller, local when they are equal. The node then forwards the request to the next hop. When no channel in that group is free, the node returns a one-cycle deny instead. Once a circuit is held, data crosses one register per hop and full travels back toward the producer. Dropping the request releases the channel at this hop. Many circuits can be held at the same time because every input and every output has its own controller.

Port grouping inside each flattened vector: inputs are ordered as left channels [0, KL), right channels [KL, KL+KR), then local inputs. Outputs are ordered as left channels [0, KL), right channels [KL, KL+KR), then local outputs.

Top module: `stream_switch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all grant_o, deny_o, req_o and valid_o bits are 0.
- R2: A new request is routed by its destination. It goes to the right output group when dest > NODE_IDX, to the left group when dest < NODE_IDX, and to the local output group when dest == NODE_IDX.
- R3: A request is granted the lowest-numbered free output in its group. One clock after the request is sampled, grant_o of that input is 1, req_o of the chosen output is 1, and dest_o of that output carries the request's destination.
- R4: When several inputs request the same group in one cycle, free channels are handed out in order of increasing input index. An input that finds no channel left gets a deny in that same cycle.
- R5: A request that finds no free channel raises deny_o for exactly one cycle and never raises grant_o. The input is not served again until its request has been seen low.
- R6: On an established circuit, data_i and valid_i of the owning input appear on data_o and valid_o of the held output one clock later. An output that is not held has valid_o at 0.
- R7: full_i of a held output is presented on full_o of its owning input in the same cycle. An input that holds no circuit has full_o at 0.
- R8: One clock after the owning request is seen low, grant_o and req_o of that circuit return to 0. The channel can then be claimed by a new request on the following cycle.
- R9: A deny arriving on a held output (deny_i) frees that output and clears grant_o of the owner. It also pulses deny_o on the owner for one cycle, all on the next clock.
- R10: Circuits on different inputs and outputs are held and stream independently at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NI | Level request per input channel |
| dest_i | input | NI*IDX_W | Destination node index per input |
| data_i | input | NI*W | Stream data per input |
| valid_i | input | NI | Data valid per input |
| grant_o | output | NI | Circuit held at this hop, per input |
| deny_o | output | NI | One-cycle refusal pulse per input |
| full_o | output | NI | Backpressure toward the producer, per input |
| req_o | output | NO | Forwarded request per output channel |
| dest_o | output | NO*IDX_W | Forwarded destination per output |
| data_o | output | NO*W | Registered stream data per output |
| valid_o | output | NO | Registered valid per output |
| deny_i | input | NO | Refusal from the next hop, per output |
| full_i | input | NO | Backpressure from the next hop, per output |

## Verification
Allocation and refusal can fall on one clock edge. That happens when two inputs contend for the last free channel in a group, or when a release and a new request meet on the same channel. The bench provokes the first case by holding one left channel and raising two requests toward the left in the same cycle. It then checks that the lower-indexed input is granted, that the other sees a single deny pulse, and that data from each input comes out on the expected output. A second case drops a request while another input is still parked after a deny. The bench confirms that the parked input gets nothing until it has dropped and raised its request again.

// File: rtl/stream_sw_pkg.sv
package stream_sw_pkg;
  typedef enum logic [1:0] {
    IN_IDLE   = 2'd0,
    IN_CONN   = 2'd1,
    IN_DENIED = 2'd2
  } in_state_e;
endpackage

// File: rtl/stream_sw_alloc.sv
module stream_sw_alloc #(
  parameter int KL       = 2,
  parameter int KR       = 2,
  parameter int KO       = 1,
  parameter int NI       = 5,
  parameter int IDX_W    = 3,
  parameter int NODE_IDX = 2,
  localparam int NO      = KL + KR + KO,
  localparam int SEL_W   = (NO > 1) ? $clog2(NO) : 1,
  localparam int SRC_W   = (NI > 1) ? $clog2(NI) : 1
) (
  input  logic [NI-1:0]            req_i,
  input  logic [NI-1:0][IDX_W-1:0] dest_i,
  input  logic [NI-1:0]            idle_i,
  input  logic [NO-1:0]            busy_i,
  output logic [NI-1:0]            win_o,
  output logic [NI-1:0]            lose_o,
  output logic [NI-1:0][SEL_W-1:0] pick_o,
  output logic [NO-1:0]            claim_o,
  output logic [NO-1:0][SRC_W-1:0] claim_src_o
);
  localparam logic [IDX_W-1:0] NODE_L = IDX_W'(NODE_IDX);

  logic [NO-1:0] taken;
  int lo, hi;
  logic found;

  // Inputs are visited in index order, so a lower index claims first.
  always_comb begin
    taken       = '0;
    win_o       = '0;
    lose_o      = '0;
    pick_o      = '0;
    claim_o     = '0;
    claim_src_o = '0;
    lo          = 0;
    hi          = 0;
    found       = 1'b0;
    for (int i = 0; i < NI; i++) begin
      if (req_i[i] && idle_i[i]) begin
        if (dest_i[i] > NODE_L) begin
          lo = KL;      hi = KL + KR;
        end else if (dest_i[i] < NODE_L) begin
          lo = 0;       hi = KL;
        end else begin
          lo = KL + KR; hi = NO;
        end
        found = 1'b0;
        for (int j = 0; j < NO; j++) begin
          if (!found && j >= lo && j < hi && !busy_i[j] && !taken[j]) begin
            found          = 1'b1;
            taken[j]       = 1'b1;
            pick_o[i]      = SEL_W'(j);
            claim_o[j]     = 1'b1;
            claim_src_o[j] = SRC_W'(i);
          end
        end
        win_o[i]  = found;
        lose_o[i] = !found;
      end
    end
  end
endmodule

// File: rtl/stream_sw_in_ctl.sv
module stream_sw_in_ctl
  import stream_sw_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             win_i,
  input  logic             lose_i,
  input  logic [SEL_W-1:0] pick_i,
  input  logic             ds_deny_i,
  output in_state_e        st_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             grant_o,
  output logic             deny_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o    <= IN_IDLE;
      sel_o   <= '0;
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
    end else begin
      deny_o <= 1'b0;
      unique case (st_o)
        IN_IDLE: begin
          if (win_i) begin
            st_o    <= IN_CONN;
            sel_o   <= pick_i;
            grant_o <= 1'b1;
          end else if (lose_i) begin
            st_o   <= IN_DENIED;
            deny_o <= 1'b1;
          end
        end
        IN_CONN: begin
          if (!req_i) begin
            st_o    <= IN_IDLE;
            grant_o <= 1'b0;
          end else if (ds_deny_i) begin
            st_o    <= IN_DENIED;
            grant_o <= 1'b0;
            deny_o  <= 1'b1;
          end
        end
        IN_DENIED: if (!req_i) st_o <= IN_IDLE;
        default: st_o <= IN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_sw_out_lane.sv
module stream_sw_out_lane #(
  parameter int W     = 16,
  parameter int IDX_W = 3,
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             claim_i,
  input  logic [SRC_W-1:0] claim_src_i,
  input  logic [IDX_W-1:0] claim_dest_i,
  input  logic             rel_i,
  input  logic             ds_deny_i,
  input  logic [W-1:0]     din_i,
  input  logic             vin_i,
  output logic             busy_o,
  output logic [SRC_W-1:0] owner_o,
  output logic [IDX_W-1:0] dest_o,
  output logic [W-1:0]     data_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      owner_o <= '0;
      dest_o  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (claim_i) begin
        busy_o  <= 1'b1;
        owner_o <= claim_src_i;
        dest_o  <= claim_dest_i;
      end else if (busy_o && (rel_i || ds_deny_i)) begin
        busy_o <= 1'b0;
      end
      data_o  <= busy_o ? din_i : '0;
      valid_o <= busy_o && vin_i;
    end
  end
endmodule

// File: rtl/stream_switch.sv
module stream_switch
  import stream_sw_pkg::*;
#(
  parameter int KL       = 2,
  parameter int KR       = 2,
  parameter int KI       = 1,
  parameter int KO       = 1,
  parameter int W        = 16,
  parameter int IDX_W    = 3,
  parameter int NODE_IDX = 2,
  localparam int NI      = KL + KR + KI,
  localparam int NO      = KL + KR + KO
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NI-1:0]            req_i,
  input  logic [NI-1:0][IDX_W-1:0] dest_i,
  input  logic [NI-1:0][W-1:0]     data_i,
  input  logic [NI-1:0]            valid_i,
  output logic [NI-1:0]            grant_o,
  output logic [NI-1:0]            deny_o,
  output logic [NI-1:0]            full_o,
  output logic [NO-1:0]            req_o,
  output logic [NO-1:0][IDX_W-1:0] dest_o,
  output logic [NO-1:0][W-1:0]     data_o,
  output logic [NO-1:0]            valid_o,
  input  logic [NO-1:0]            deny_i,
  input  logic [NO-1:0]            full_i
);
  localparam int SEL_W = (NO > 1) ? $clog2(NO) : 1;
  localparam int SRC_W = (NI > 1) ? $clog2(NI) : 1;

  logic [NI-1:0]            idle, win, lose;
  logic [NI-1:0][SEL_W-1:0] pick, sel;
  logic [NO-1:0]            claim;
  logic [NO-1:0][SRC_W-1:0] claim_src, owner;
  in_state_e                st [NI];

  stream_sw_alloc #(
    .KL(KL), .KR(KR), .KO(KO), .NI(NI), .IDX_W(IDX_W), .NODE_IDX(NODE_IDX)
  ) u_alloc (
    .req_i(req_i), .dest_i(dest_i), .idle_i(idle), .busy_i(req_o),
    .win_o(win), .lose_o(lose), .pick_o(pick),
    .claim_o(claim), .claim_src_o(claim_src)
  );

  for (genvar i = 0; i < NI; i++) begin : g_in
    logic conn;
    assign conn      = (st[i] == IN_CONN);
    assign idle[i]   = (st[i] == IN_IDLE);
    assign full_o[i] = conn && full_i[sel[i]];

    stream_sw_in_ctl #(.SEL_W(SEL_W)) u_in (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i[i]),
      .win_i(win[i]), .lose_i(lose[i]), .pick_i(pick[i]),
      .ds_deny_i(conn && req_o[sel[i]] && deny_i[sel[i]]),
      .st_o(st[i]), .sel_o(sel[i]), .grant_o(grant_o[i]), .deny_o(deny_o[i])
    );
  end

  for (genvar j = 0; j < NO; j++) begin : g_out
    stream_sw_out_lane #(.W(W), .IDX_W(IDX_W), .SRC_W(SRC_W)) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .claim_i(claim[j]), .claim_src_i(claim_src[j]),
      .claim_dest_i(dest_i[claim_src[j]]),
      .rel_i(!req_i[owner[j]]), .ds_deny_i(deny_i[j]),
      .din_i(data_i[owner[j]]), .vin_i(valid_i[owner[j]]),
      .busy_o(req_o[j]), .owner_o(owner[j]), .dest_o(dest_o[j]),
      .data_o(data_o[j]), .valid_o(valid_o[j])
    );
  end
endmodule

// File: rtl/stream_switch_chk.sv
module stream_switch_chk #(
  parameter int NI = 5,
  parameter int NO = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NI-1:0] req_i,
  input logic [NI-1:0] grant_o,
  input logic [NI-1:0] deny_o,
  input logic [NO-1:0] req_o,
  input logic [NO-1:0] valid_o
);
  // R10: every held input maps to exactly one held output
  assert_circuit_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == $countones(req_o));

  for (genvar i = 0; i < NI; i++) begin : g_i
    assert_no_grant_with_deny_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(grant_o[i] && deny_o[i]));
    assert_deny_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deny_o[i] |=> !deny_o[i]);
    assert_deny_follows_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(deny_o[i]) |-> $past(req_i[i]));
    assert_release_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[i] && !req_i[i]) |=> !grant_o[i]);
  end

  for (genvar j = 0; j < NO; j++) begin : g_o
    assert_valid_only_on_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_o[j]) |-> $past(req_o[j]));
  end
endmodule

bind stream_switch stream_switch_chk #(.NI(KL + KR + KI), .NO(KL + KR + KO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .grant_o(grant_o),
  .deny_o(deny_o), .req_o(req_o), .valid_o(valid_o)
);

// File: tb/tb_stream_switch.sv
module tb_stream_switch;
  localparam int KL = 2, KR = 2, KI = 1, KO = 1, W = 16, IDX_W = 3, NODE = 2;
  localparam int NI = KL + KR + KI, NO = KL + KR + KO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0]            req = '0, valid = '0;
  logic [NI-1:0][IDX_W-1:0] dest = '0;
  logic [NI-1:0][W-1:0]     data = '0;
  logic [NI-1:0]            grant, deny, full;
  logic [NO-1:0]            req_o, valid_o;
  logic [NO-1:0]            deny_i = '0, full_i = '0;
  logic [NO-1:0][IDX_W-1:0] dest_o;
  logic [NO-1:0][W-1:0]     data_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stream_switch #(.KL(KL), .KR(KR), .KI(KI), .KO(KO), .W(W), .IDX_W(IDX_W),
                  .NODE_IDX(NODE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dest_i(dest), .data_i(data),
    .valid_i(valid), .grant_o(grant), .deny_o(deny), .full_o(full),
    .req_o(req_o), .dest_o(dest_o), .data_o(data_o), .valid_o(valid_o),
    .deny_i(deny_i), .full_i(full_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clear_all();
    req = '0; valid = '0; data = '0; deny_i = '0; full_i = '0;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1 grant", 32'(grant), 0);  chk("R1 deny", 32'(deny), 0);
    chk("R1 req_o", 32'(req_o), 0);  chk("R1 valid_o", 32'(valid_o), 0);
  endtask

  task automatic t_right_stream();
    req[4] = 1; dest[4] = 3'd5; step();
    chk("R2/R3 grant in4", 32'(grant[4]), 1);
    chk("R3 lowest right out2", 32'(req_o), 32'b00100);
    chk("R3 dest_o out2", 32'(dest_o[2]), 5);
    data[4] = 16'hA5A5; valid[4] = 1; step();
    chk("R6 data out2", 32'(data_o[2]), 32'hA5A5);
    chk("R6 valid out2", 32'(valid_o[2]), 1);
    full_i[2] = 1; #1;
    chk("R7 full back to in4", 32'(full), 32'b10000);
    full_i[2] = 0; valid[4] = 0; step();
    chk("R6 valid drop", 32'(valid_o[2]), 0);
  endtask

  task automatic t_deny_release();
    req[0] = 1; dest[0] = 3'd7; step();
    chk("R10 second circuit in0", 32'(grant[0]), 1);
    chk("R10 out3 held", 32'(req_o[3]), 1);
    req[1] = 1; dest[1] = 3'd6; step();
    chk("R5 deny pulse in1", 32'(deny[1]), 1);
    chk("R5 no grant in1", 32'(grant[1]), 0);
    step();
    chk("R5 deny one cycle", 32'(deny[1]), 0);
    req[4] = 0; step();
    chk("R8 out2 released", 32'(req_o[2]), 0);
    chk("R8 grant in4 low", 32'(grant[4]), 0);
    step();
    chk("R5 parked in1 not served", 32'(grant[1]), 0);
    req[1] = 0; step();
    req[1] = 1; step();
    chk("R8 reuse out2 by in1", 32'(grant[1]), 1);
    chk("R8 out2 held again", 32'(req_o[2]), 1);
    full_i[3] = 1; #1;
    chk("R7 full only to owner in0", 32'(full), 32'b00001);
    clear_all();
  endtask

  task automatic t_priority();
    req[2] = 1; dest[2] = 3'd0; step();
    chk("R2 left out0 for in2", 32'(req_o), 32'b00001);
    req[3] = 1; dest[3] = 3'd1; req[4] = 1; dest[4] = 3'd0; step();
    chk("R4 in3 wins last left", 32'(grant), 32'b01100);
    chk("R4 in4 denied same cycle", 32'(deny), 32'b10000);
    data[2] = 16'h1111; data[3] = 16'h2222; valid[2] = 1; valid[3] = 1; step();
    chk("R4 out0 carries in2", 32'(data_o[0]), 32'h1111);
    chk("R4 out1 carries in3", 32'(data_o[1]), 32'h2222);
    clear_all();
  endtask

  task automatic t_local_dsdeny();
    req[0] = 1; dest[0] = 3'd2; step();
    chk("R2 local out4", 32'(req_o), 32'b10000);
    chk("R3 local dest_o", 32'(dest_o[4]), 2);
    deny_i[4] = 1; step();
    deny_i[4] = 0;
    chk("R9 out4 freed", 32'(req_o[4]), 0);
    chk("R9 grant cleared", 32'(grant[0]), 0);
    chk("R9 deny to owner", 32'(deny[0]), 1);
    step();
    chk("R9 deny one cycle", 32'(deny[0]), 0);
    clear_all();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_right_stream();
    t_deny_release();
    t_priority();
    t_local_dsdeny();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule